// File: doc/BRIEF.md
# ALU Result Shifter and Flag Generator

This block is the last stage behind the arithmetic core of an 8-bit datapath. It receives the raw ALU result together with the adder carry-out, the sign bits of both operands and the carry bit held in the status register. From these it produces the final data word and four condition flags. It is purely combinational and holds no state.

A 2-bit shift control either passes the result through, moves it one place toward the least significant bit, moves it one place toward the most significant bit, or blanks it to zero. A second 2-bit control picks the carry source: the status carry, a constant 0, a constant 1 or the adder carry-out. That chosen value is the fill bit for any shift. When no shift is in progress, the chosen value is also the carry output.

A single fill path is enough to give the usual shift family:
- rotate through carry uses the status carry as the fill;
- logical shifts use a constant 0;
- shifts that fill with ones use a constant 1.

The data path has no handshake. Results follow the inputs in the same cycle, so there is no back-pressure to manage. The sequencing logic that surrounds the block registers the outputs where it needs to.

Top module: `alu_post_shift`

## Requirements
- R1: With shift select 2'b00 the data output equals the result input unchanged, and the carry output equals the selected carry value.
- R2: With shift select 2'b01 (right), output bit i equals result bit i+1, and the top output bit equals the selected carry value. The carry output equals result bit 0.
- R3: With shift select 2'b10 (left), output bit i equals result bit i-1, and output bit 0 equals the selected carry value. The carry output equals the top result bit.
- R4: With shift select 2'b11 the data output is all zeros and the carry output equals the selected carry value.
- R5: Carry select 2'b00 picks the status carry input, 2'b01 picks constant 0, 2'b10 picks constant 1 and 2'b11 picks the adder carry-out.
- R6: The zero flag is 1 exactly when every bit of the final data output is 0.
- R7: The negative flag equals the top bit of the final data output.
- R8: The overflow flag is 1 exactly when the two operand sign bits are equal and the top bit of the unshifted result differs from them. This holds for every shift select value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| res_i | input | W | Raw ALU result |
| add_cy_i | input | 1 | Adder carry-out |
| lhs_msb_i | input | 1 | Sign bit of the left operand |
| rhs_msb_i | input | 1 | Sign bit of the right operand, after any inversion for subtraction |
| stat_cy_i | input | 1 | Carry bit from the status register |
| cy_sel_i | input | 2 | Carry source select (R5 encoding) |
| sh_sel_i | input | 2 | Shift select (R1 to R4 encoding) |
| data_o | output | W | Final data word |
| cy_o | output | 1 | Carry flag |
| zero_o | output | 1 | Zero flag |
| neg_o | output | 1 | Negative flag |
| ovf_o | output | 1 | Overflow flag |

## Verification
The bench builds the block with its default width of W = 8. At that width the whole input space is only 16 bits wide: 8 result bits, four single-bit inputs and two 2-bit selects. The bench therefore drives every one of the 65536 combinations, one per clock, against its behavioural model. That sweep reaches every pairing of shift mode and carry source, including the edge bits leaving at both ends and the blanking mode. It also covers every pairing of operand sign bits with result sign bit for overflow. A few directed vectors are applied first, so that the rotate, logical and fill-with-ones cases are each reported under their own names.

// File: rtl/alu_post_pkg.sv
package alu_post_pkg;
  typedef enum logic [1:0] {
    SH_PASS  = 2'b00,
    SH_RIGHT = 2'b01,
    SH_LEFT  = 2'b10,
    SH_BLANK = 2'b11
  } shift_mode_e;

  typedef enum logic [1:0] {
    CY_STATUS = 2'b00,
    CY_ZERO   = 2'b01,
    CY_ONE    = 2'b10,
    CY_ADDER  = 2'b11
  } carry_src_e;
endpackage

// File: rtl/aps_carry_mux.sv
module aps_carry_mux
  import alu_post_pkg::*;
(
  input  logic [1:0] sel_i,
  input  logic       stat_cy_i,
  input  logic       add_cy_i,
  output logic       cy_o
);
  carry_src_e src;
  assign src = carry_src_e'(sel_i);

  // R5: carry source decode
  always_comb begin
    unique case (src)
      CY_STATUS: cy_o = stat_cy_i;
      CY_ZERO:   cy_o = 1'b0;
      CY_ONE:    cy_o = 1'b1;
      CY_ADDER:  cy_o = add_cy_i;
      default:   cy_o = 1'b0;
    endcase
  end
endmodule

// File: rtl/aps_shifter.sv
module aps_shifter
  import alu_post_pkg::*;
#(
  parameter int W = 8
) (
  input  logic [W-1:0] res_i,
  input  logic         fill_i,
  input  logic [1:0]   mode_i,
  output logic [W-1:0] data_o,
  output logic         cy_o
);
  localparam int MSB = W - 1;

  shift_mode_e mode;
  assign mode = shift_mode_e'(mode_i);

  logic [W-1:0] from_above;
  logic [W-1:0] from_below;

  // Each bit picks its upper or lower neighbour; the end bits take the fill.
  for (genvar i = 0; i < W; i++) begin : g_bit
    if (i == MSB) begin : g_top
      assign from_above[i] = fill_i;
    end else begin : g_mid_hi
      assign from_above[i] = res_i[i+1];
    end
    if (i == 0) begin : g_bot
      assign from_below[i] = fill_i;
    end else begin : g_mid_lo
      assign from_below[i] = res_i[i-1];
    end
  end

  always_comb begin
    unique case (mode)
      SH_PASS: begin
        data_o = res_i;
        cy_o   = fill_i;
      end
      SH_RIGHT: begin
        data_o = from_above;
        cy_o   = res_i[0];
      end
      SH_LEFT: begin
        data_o = from_below;
        cy_o   = res_i[MSB];
      end
      default: begin
        data_o = '0;
        cy_o   = fill_i;
      end
    endcase
  end
endmodule

// File: rtl/aps_flags.sv
module aps_flags #(
  parameter int W = 8
) (
  input  logic [W-1:0] data_i,
  input  logic         raw_msb_i,
  input  logic         lhs_msb_i,
  input  logic         rhs_msb_i,
  output logic         zero_o,
  output logic         neg_o,
  output logic         ovf_o
);
  assign zero_o = ~|data_i;
  assign neg_o  = data_i[W-1];
  // Operand signs agree, but the unshifted result sign disagrees with them.
  assign ovf_o  = ~(lhs_msb_i ^ rhs_msb_i) & (raw_msb_i ^ lhs_msb_i);
endmodule

// File: rtl/alu_post_shift.sv
module alu_post_shift #(
  parameter int W = 8
) (
  input  logic [W-1:0] res_i,
  input  logic         add_cy_i,
  input  logic         lhs_msb_i,
  input  logic         rhs_msb_i,
  input  logic         stat_cy_i,
  input  logic [1:0]   cy_sel_i,
  input  logic [1:0]   sh_sel_i,
  output logic [W-1:0] data_o,
  output logic         cy_o,
  output logic         zero_o,
  output logic         neg_o,
  output logic         ovf_o
);
  logic fill;

  aps_carry_mux u_cmux (
    .sel_i     (cy_sel_i),
    .stat_cy_i (stat_cy_i),
    .add_cy_i  (add_cy_i),
    .cy_o      (fill)
  );

  aps_shifter #(.W(W)) u_shift (
    .res_i  (res_i),
    .fill_i (fill),
    .mode_i (sh_sel_i),
    .data_o (data_o),
    .cy_o   (cy_o)
  );

  aps_flags #(.W(W)) u_flags (
    .data_i    (data_o),
    .raw_msb_i (res_i[W-1]),
    .lhs_msb_i (lhs_msb_i),
    .rhs_msb_i (rhs_msb_i),
    .zero_o    (zero_o),
    .neg_o     (neg_o),
    .ovf_o     (ovf_o)
  );
endmodule

// File: rtl/alu_post_shift_chk.sv
module alu_post_shift_chk #(
  parameter int W = 8
) (
  input logic [W-1:0] res_i,
  input logic         add_cy_i,
  input logic         lhs_msb_i,
  input logic         rhs_msb_i,
  input logic         stat_cy_i,
  input logic [1:0]   cy_sel_i,
  input logic [1:0]   sh_sel_i,
  input logic [W-1:0] data_o,
  input logic         cy_o,
  input logic         zero_o,
  input logic         neg_o,
  input logic         ovf_o
);
  logic known;
  logic sel_cy;
  assign known = !$isunknown({res_i, add_cy_i, lhs_msb_i, rhs_msb_i,
                              stat_cy_i, cy_sel_i, sh_sel_i});
  assign sel_cy = (cy_sel_i == 2'd0) ? stat_cy_i :
                  (cy_sel_i == 2'd3) ? add_cy_i : cy_sel_i[1];

  always_comb begin
    if (known) begin
      if (sh_sel_i == 2'b00)
        assert_pass_R1: assert (data_o == res_i && cy_o == sel_cy);
      if (sh_sel_i == 2'b01)
        assert_right_R2: assert (cy_o == res_i[0] && data_o[W-2:0] == res_i[W-1:1]
                                 && data_o[W-1] == sel_cy);
      if (sh_sel_i == 2'b10)
        assert_left_R3: assert (cy_o == res_i[W-1] && data_o[W-1:1] == res_i[W-2:0]
                                && data_o[0] == sel_cy);
      if (sh_sel_i == 2'b11)
        assert_blank_R4: assert (data_o == '0 && cy_o == sel_cy);
      if (cy_sel_i == 2'b01 && (sh_sel_i == 2'b00 || sh_sel_i == 2'b11))
        assert_force0_R5: assert (!cy_o);
      if (cy_sel_i == 2'b10 && (sh_sel_i == 2'b00 || sh_sel_i == 2'b11))
        assert_force1_R5: assert (cy_o);
      assert_zero_R6: assert (zero_o == (data_o == '0));
      assert_neg_R7: assert (neg_o == data_o[W-1]);
      assert_ovf_R8: assert (ovf_o == ((lhs_msb_i == rhs_msb_i) && (res_i[W-1] != lhs_msb_i)));
    end
  end
endmodule

bind alu_post_shift alu_post_shift_chk #(.W(W)) u_chk (.*);

// File: tb/tb_alu_post_shift.sv
`timescale 1ns/1ps
module tb_alu_post_shift;
  localparam int W = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #4 clk = ~clk;

  logic [W-1:0] res_i = '0;
  logic add_cy_i = 1'b0, lhs_msb_i = 1'b0, rhs_msb_i = 1'b0, stat_cy_i = 1'b0;
  logic [1:0] cy_sel_i = 2'b00, sh_sel_i = 2'b00;
  logic [W-1:0] data_o;
  logic cy_o, zero_o, neg_o, ovf_o;

  int n_run = 0;
  int n_fail = 0;
  bit finished = 0;

  alu_post_shift #(.W(W)) dut (.*);

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Behavioural reference: returns {ovf, neg, zero, cy, data}
  function automatic int model(int r, int ac, int l, int rr, int sc, int cs, int ss);
    int fill, d, c, z, n, v;
    case (cs)
      0: fill = sc;
      1: fill = 0;
      2: fill = 1;
      default: fill = ac;
    endcase
    case (ss)
      0: begin d = r; c = fill; end
      1: begin d = (r / 2) + fill * 128; c = r % 2; end
      2: begin d = ((r * 2) % 256) + fill; c = r / 128; end
      default: begin d = 0; c = fill; end
    endcase
    z = (d == 0) ? 1 : 0;
    n = d / 128;
    v = (l == rr && (r / 128) != l) ? 1 : 0;
    return d + c * 256 + z * 512 + n * 1024 + v * 2048;
  endfunction

  task automatic apply(input int r, input int ac, input int l, input int rr,
                       input int sc, input int cs, input int ss);
    @(posedge clk);
    #1;
    res_i = W'(r); add_cy_i = ac[0]; lhs_msb_i = l[0]; rhs_msb_i = rr[0];
    stat_cy_i = sc[0]; cy_sel_i = cs[1:0]; sh_sel_i = ss[1:0];
  endtask

  task automatic compare(input int r, input int ac, input int l, input int rr,
                         input int sc, input int cs, input int ss);
    int e;
    string dreq;
    string creq;
    e = model(r, ac, l, rr, sc, cs, ss);
    @(negedge clk);
    dreq = (ss == 0) ? "R1" : (ss == 1) ? "R2" : (ss == 2) ? "R3" : "R4";
    creq = (ss == 0 || ss == 3) ? "R5" : dreq;
    chk(int'(data_o) == e % 256, dreq, int'(data_o), e % 256);
    chk(int'(cy_o) == (e / 256) % 2, creq, int'(cy_o), (e / 256) % 2);
    chk(int'(zero_o) == (e / 512) % 2, "R6", int'(zero_o), (e / 512) % 2);
    chk(int'(neg_o) == (e / 1024) % 2, "R7", int'(neg_o), (e / 1024) % 2);
    chk(int'(ovf_o) == (e / 2048) % 2, "R8", int'(ovf_o), (e / 2048) % 2);
  endtask

  task automatic vec(input int r, input int ac, input int l, input int rr,
                     input int sc, input int cs, input int ss);
    apply(r, ac, l, rr, sc, cs, ss);
    compare(r, ac, l, rr, sc, cs, ss);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    // reset state: all inputs zero -> zero output, zero flag set
    @(negedge clk);
    chk(data_o == '0, "R1 reset", int'(data_o), 0);
    chk(zero_o == 1'b1, "R6 reset", int'(zero_o), 1);
    rst_n = 1'b1;

    // R2 rotate right through status carry: 0x81, cin 0 -> 0x40, cy 1
    vec(8'h81, 0, 0, 0, 0, 0, 1);
    chk(data_o == 8'h40 && cy_o, "R2 rotate right", int'(data_o), 8'h40);
    // R3 logical left with forced 0: 0x81 -> 0x02, cy 1
    vec(8'h81, 1, 0, 0, 1, 1, 2);
    chk(data_o == 8'h02 && cy_o, "R3 logical left", int'(data_o), 8'h02);
    // R2/R5 fill with ones right: 0x00 -> 0x80, neg set
    vec(8'h00, 0, 0, 0, 0, 2, 1);
    chk(data_o == 8'h80 && neg_o, "R5 ones fill right", int'(data_o), 8'h80);
    // R4 blank mode, adder carry selected
    vec(8'hFF, 1, 0, 0, 0, 3, 3);
    chk(data_o == 8'h00 && cy_o && zero_o, "R4 blank", int'(data_o), 0);
    // R6 left shift shifts out the only set bit -> zero
    vec(8'h80, 0, 0, 0, 0, 1, 2);
    chk(zero_o && cy_o, "R6 zero after shift", int'(zero_o), 1);
    // R8 overflow independent of blanking: 0+0 -> negative raw result
    vec(8'h80, 0, 0, 0, 0, 0, 3);
    chk(ovf_o == 1'b1, "R8 ovf under blank", int'(ovf_o), 1);

    // exhaustive sweep of every input combination
    for (int v = 0; v < 65536; v++) begin
      vec(v % 256, (v / 256) % 2, (v / 512) % 2, (v / 1024) % 2,
          (v / 2048) % 2, (v / 4096) % 4, (v / 16384) % 4);
    end

    if (!finished) begin
      finished = 1;
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      n_run++;
      n_fail++;
      $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule